// File: doc/BRIEF.md
# Processor Run/Stop Controller

This block keeps track of which virtual processors (VPs) in a cluster are executing, and starts or halts them when software asks. A simple request/response slave port accepts register writes and reads. Writing a one-bit-per-VP mask to the start register brings up every selected VP that is currently halted. It gives each such VP a one-clock reset pulse and marks it running. Writing a mask to the halt register sends a one-clock halt request to every selected VP that is currently running, and marks it halted. VPs whose state would not change are not touched.

The register set can be reached through two address windows that behave identically. One is the local-cluster window and the other is the "other core" window. The number of VPs and the set of VPs brought up after reset are elaboration parameters. If the boot set names a VP beyond the configured count, an elaboration-time check rejects the configuration. The running bitmap is held as a 64-bit value. Every request gets a response one cycle later, carrying read data and an error flag for unsupported accesses.

Top module: `vp_runctl`

## Requirements
- R1: While reset is asserted, all VP pulses and the response valid are low and every VP counts as halted. In the first clock after reset is released, exactly the VPs in START_MASK receive a one-cycle `vp_reset` pulse and become running. No halt request is raised.
- R2: A write to the start register (window offset 0x00) pulses `vp_reset` for each VP whose data bit is 1 and that is halted, and marks that VP running. VPs that are already running get no pulse and keep their state.
- R3: A write to the halt register (window offset 0x08) pulses `vp_halt` for each VP whose data bit is 1 and that is running, and marks that VP halted. VPs that are already halted get no pulse.
- R4: Write-data bits at positions NUM_VP and above have no effect on start or halt. Bits NUM_VP and above of the running bitmap always read as 0.
- R5: Window A (base 0x000) and window B (base 0x100) decode the same three registers at the same offsets and act identically.
- R6: Every accepted request produces `rsp_valid` high for exactly the next cycle. The pulses caused by a command appear in that same cycle. A read of the running register (window offset 0x10) returns the bitmap including all commands accepted in earlier cycles, even the immediately preceding one.
- R7: Any other access is unsupported: a read of start or halt, any access at another offset or outside both windows, or a write to the running register. It returns zero read data with `rsp_err` = 1, raises no pulse and leaves the bitmap unchanged.
- R8: Each `vp_reset` and `vp_halt` pulse lasts one clock and is low in cycles without a command response. A start and a halt of the same VP accepted in back-to-back cycles take effect in that order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Byte address of the register |
| req_wdata | input | 64 | Write data, one bit per VP |
| rsp_valid | output | 1 | Response for the previous cycle's request |
| rsp_rdata | output | 64 | Read data (zero for writes and unsupported reads) |
| rsp_err | output | 1 | Previous request hit no supported register |
| vp_reset | output | NUM_VP | One-cycle reset pulse per VP being started |
| vp_halt | output | NUM_VP | One-cycle halt request per VP being stopped |

## Verification
The bench starts VPs that are already running and halts VPs that are already halted. A design that ignores the current state would emit spurious reset or halt pulses. It writes masks with bits above the VP count set, which catches a missing mask that would corrupt the bitmap or pulse nonexistent VPs. It issues start, halt and read back-to-back across both windows, so a design that delayed the bitmap update, decoded only one window or swapped the order would return stale or wrong read data. It also targets the unsupported accesses: a read of a command register and a write of the status register must return zero with the error flag and leave the state unchanged.

// File: rtl/vp_runctl_pkg.sv
package vp_runctl_pkg;

  localparam int unsigned BUS_W = 64;

  // register offsets inside one window
  localparam logic [7:0] OFS_START = 8'h00;
  localparam logic [7:0] OFS_HALT  = 8'h08;
  localparam logic [7:0] OFS_STAT  = 8'h10;

  typedef enum logic [1:0] {
    OP_NONE  = 2'd0,
    OP_START = 2'd1,
    OP_HALT  = 2'd2,
    OP_STAT  = 2'd3
  } reg_op_e;

  typedef struct packed {
    reg_op_e op;
    logic    bad;
  } decode_t;

  // bits that name an existing VP
  function automatic logic [BUS_W-1:0] vp_mask(input int unsigned n);
    if (n >= BUS_W) return '1;
    return (64'd1 << n) - 64'd1;
  endfunction

  // VPs asked to start that are not yet running
  function automatic logic [BUS_W-1:0] newly_started(input logic [BUS_W-1:0] req,
                                                     input logic [BUS_W-1:0] cur);
    return req & ~cur;
  endfunction

  // VPs asked to halt that are running
  function automatic logic [BUS_W-1:0] newly_halted(input logic [BUS_W-1:0] req,
                                                    input logic [BUS_W-1:0] cur);
    return req & cur;
  endfunction

endpackage

// File: rtl/vp_addr_decode.sv
module vp_addr_decode
  import vp_runctl_pkg::*;
#(
  parameter int unsigned          ADDR_W   = 12,
  parameter int unsigned          WIN_BITS = 8,
  parameter logic [ADDR_W-1:0]    WIN_A    = 12'h000,
  parameter logic [ADDR_W-1:0]    WIN_B    = 12'h100
) (
  input  logic              valid,
  input  logic              write,
  input  logic [ADDR_W-1:0] addr,
  output decode_t           dec
);

  localparam int unsigned NUM_WIN = 2;
  localparam int unsigned HI_W    = ADDR_W - WIN_BITS;

  logic [NUM_WIN-1:0]   win_hit;
  logic [WIN_BITS-1:0]  offset;
  logic                 any_hit;

  assign offset = addr[WIN_BITS-1:0];

  for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
    localparam logic [ADDR_W-1:0] BASE = (w == 0) ? WIN_A : WIN_B;
    assign win_hit[w] = (addr[ADDR_W-1:WIN_BITS] == BASE[ADDR_W-1:WIN_BITS]);
  end

  assign any_hit = |win_hit;

  always_comb begin
    dec.op  = OP_NONE;
    dec.bad = 1'b0;
    if (valid) begin
      if (any_hit && write && offset == WIN_BITS'(OFS_START))
        dec.op = OP_START;
      else if (any_hit && write && offset == WIN_BITS'(OFS_HALT))
        dec.op = OP_HALT;
      else if (any_hit && !write && offset == WIN_BITS'(OFS_STAT))
        dec.op = OP_STAT;
      else
        dec.bad = 1'b1;
    end
  end

  // HI_W kept for readability of the split
  logic unused_hi;
  assign unused_hi = (HI_W == 0);

endmodule

// File: rtl/vp_run_state.sv
module vp_run_state
  import vp_runctl_pkg::*;
#(
  parameter int unsigned       NUM_VP     = 1,
  parameter logic [BUS_W-1:0]  START_MASK = 64'h1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_fire,
  input  reg_op_e           op,
  input  logic [BUS_W-1:0]  wdata,
  output logic [BUS_W-1:0]  running,
  output logic [NUM_VP-1:0] vp_reset,
  output logic [NUM_VP-1:0] vp_halt
);

  localparam logic [BUS_W-1:0] VALID = vp_mask(NUM_VP);

  logic [BUS_W-1:0] running_q;
  logic [BUS_W-1:0] req_bits;
  logic [BUS_W-1:0] after_boot, boot_bits;
  logic [BUS_W-1:0] start_bits, after_start;
  logic [BUS_W-1:0] halt_bits, running_d;
  logic [NUM_VP-1:0] reset_q, halt_q;

  assign req_bits = wdata & VALID;

  // boot start is applied first, then the bus command, in that order
  always_comb begin
    boot_bits   = boot_fire ? newly_started(START_MASK & VALID, running_q) : '0;
    after_boot  = running_q | boot_bits;
    start_bits  = (op == OP_START) ? newly_started(req_bits, after_boot) : '0;
    after_start = after_boot | start_bits;
    halt_bits   = (op == OP_HALT) ? newly_halted(req_bits, after_start) : '0;
    running_d   = after_start & ~halt_bits;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      running_q <= '0;
      reset_q   <= '0;
      halt_q    <= '0;
    end else begin
      running_q <= running_d;
      reset_q   <= NUM_VP'(boot_bits | start_bits);
      halt_q    <= NUM_VP'(halt_bits);
    end
  end

  assign running  = running_q;
  assign vp_reset = reset_q;
  assign vp_halt  = halt_q;

endmodule

// File: rtl/vp_bus_resp.sv
module vp_bus_resp
  import vp_runctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              valid,
  input  decode_t           dec,
  input  logic [BUS_W-1:0]  running,
  output logic              rsp_valid,
  output logic [BUS_W-1:0]  rsp_rdata,
  output logic              rsp_err
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
      rsp_err   <= 1'b0;
    end else begin
      rsp_valid <= valid;
      rsp_rdata <= (valid && dec.op == OP_STAT) ? running : '0;
      rsp_err   <= valid && dec.bad;
    end
  end

endmodule

// File: rtl/vp_runctl.sv
module vp_runctl
  import vp_runctl_pkg::*;
#(
  parameter int unsigned       NUM_VP     = 1,
  parameter logic [63:0]       START_MASK = 64'h1,
  parameter int unsigned       ADDR_W     = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [63:0]       req_wdata,
  output logic              rsp_valid,
  output logic [63:0]       rsp_rdata,
  output logic              rsp_err,
  output logic [NUM_VP-1:0] vp_reset,
  output logic [NUM_VP-1:0] vp_halt
);

  localparam logic [BUS_W-1:0] VALID = vp_mask(NUM_VP);

  initial begin : cfg_check
    assert (NUM_VP >= 1 && NUM_VP <= BUS_W)
      else $error("vp_runctl: NUM_VP %0d out of range", NUM_VP);
    assert ((START_MASK & ~VALID) == '0)
      else $error("vp_runctl: START_MASK names VPs beyond NUM_VP");
  end

  // named internal events for the checker
  logic             boot_q;
  logic             boot_fire;
  decode_t          dec;
  logic [BUS_W-1:0] running;

  always_ff @(posedge clk) begin
    if (!rst_n) boot_q <= 1'b1;
    else        boot_q <= 1'b0;
  end
  assign boot_fire = boot_q;

  vp_addr_decode #(
    .ADDR_W   (ADDR_W),
    .WIN_BITS (8),
    .WIN_A    (ADDR_W'(12'h000)),
    .WIN_B    (ADDR_W'(12'h100))
  ) u_dec (
    .valid (req_valid),
    .write (req_write),
    .addr  (req_addr),
    .dec   (dec)
  );

  vp_run_state #(
    .NUM_VP     (NUM_VP),
    .START_MASK (START_MASK)
  ) u_state (
    .clk       (clk),
    .rst_n     (rst_n),
    .boot_fire (boot_fire),
    .op        (dec.op),
    .wdata     (req_wdata),
    .running   (running),
    .vp_reset  (vp_reset),
    .vp_halt   (vp_halt)
  );

  vp_bus_resp u_resp (
    .clk       (clk),
    .rst_n     (rst_n),
    .valid     (req_valid),
    .dec       (dec),
    .running   (running),
    .rsp_valid (rsp_valid),
    .rsp_rdata (rsp_rdata),
    .rsp_err   (rsp_err)
  );

endmodule

// File: rtl/vp_runctl_chk.sv
module vp_runctl_chk #(
  parameter int unsigned NUM_VP = 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              boot_fire,
  input logic [63:0]       running,
  input logic              rsp_valid,
  input logic              rsp_err,
  input logic [63:0]       rsp_rdata,
  input logic [NUM_VP-1:0] vp_reset,
  input logic [NUM_VP-1:0] vp_halt
);

  localparam logic [63:0] VALID = (NUM_VP >= 64) ? '1 : ((64'd1 << NUM_VP) - 64'd1);

  // boot start fires in one cycle only
  p_boot_once_r1: assert property (@(posedge clk) disable iff (!rst_n)
    boot_fire |=> !boot_fire);

  // any VP that became running got a reset pulse with it
  p_start_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (NUM_VP'(running & ~$past(running)) & ~vp_reset) == '0);

  // any VP that stopped running got a halt request with it
  p_halt_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (NUM_VP'($past(running) & ~running) & ~vp_halt) == '0);

  // bitmap never holds nonexistent VPs
  p_mask_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (running & ~VALID) == '0);

  // one response per request, next cycle
  p_rsp_follow_r6: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);

  // unsupported access returns zero
  p_unsup_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_err) |-> rsp_rdata == '0);

  // outside the boot step no VP is both reset and halted
  p_exclusive_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(boot_fire) |-> (vp_reset & vp_halt) == '0);

endmodule

bind vp_runctl vp_runctl_chk #(.NUM_VP(NUM_VP)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .boot_fire (boot_fire),
  .running   (running),
  .rsp_valid (rsp_valid),
  .rsp_err   (rsp_err),
  .rsp_rdata (rsp_rdata),
  .vp_reset  (vp_reset),
  .vp_halt   (vp_halt)
);

// File: tb/vp_runctl_test.sv
module vp_runctl_test;

  localparam int CLK_PERIOD = 10;
  localparam int NVP        = 6;
  localparam logic [63:0] BOOT = 64'h05;
  localparam logic [63:0] VMASK = 64'h3F;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_write;
  logic [11:0]       req_addr;
  logic [63:0]       req_wdata;
  logic              rsp_valid;
  logic [63:0]       rsp_rdata;
  logic              rsp_err;
  logic [NVP-1:0]    vp_reset;
  logic [NVP-1:0]    vp_halt;

  always #(CLK_PERIOD/2) clk = ~clk;

  vp_runctl #(.NUM_VP(NVP), .START_MASK(BOOT), .ADDR_W(12)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_wdata(req_wdata), .rsp_valid(rsp_valid),
    .rsp_rdata(rsp_rdata), .rsp_err(rsp_err), .vp_reset(vp_reset), .vp_halt(vp_halt)
  );

  typedef struct {
    logic [63:0]    rdata;
    logic           err;
    logic [NVP-1:0] rst;
    logic [NVP-1:0] hlt;
    string          tag;
  } exp_t;

  exp_t        exp_q[$];
  logic [63:0] model;
  int          n_cmp  = 0;
  int          n_bad  = 0;
  bit          mon_en = 1'b0;
  bit          done   = 1'b0;

  task automatic check(input bit ok, input string tag, input logic [63:0] act,
                       input logic [63:0] expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, expv);
    end
  endtask

  // driver: bench's own model of the register behaviour, then drive one cycle
  task automatic issue(input bit wr, input logic [11:0] a, input logic [63:0] d,
                       input string tag);
    exp_t e;
    bit   win_ok;
    logic [7:0] off;
    win_ok  = (a[11:8] == 4'h0) || (a[11:8] == 4'h1);
    off     = a[7:0];
    e.rdata = '0; e.err = 1'b0; e.rst = '0; e.hlt = '0; e.tag = tag;
    if (win_ok && wr && off == 8'h00) begin
      e.rst = NVP'((d & VMASK) & ~model);
      model = model | (d & VMASK);
    end else if (win_ok && wr && off == 8'h08) begin
      e.hlt = NVP'((d & VMASK) & model);
      model = model & ~(d & VMASK);
    end else if (win_ok && !wr && off == 8'h10) begin
      e.rdata = model;
    end else begin
      e.err = 1'b1;
    end
    exp_q.push_back(e);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
  endtask

  // monitor: pop and compare each response
  always @(negedge clk) begin
    if (mon_en) begin
      if (rsp_valid) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R6 unexpected response", 64'd1, 64'd0);
        end else begin
          exp_t e;
          bit ok;
          e  = exp_q.pop_front();
          ok = (rsp_rdata === e.rdata) && (rsp_err === e.err) &&
               (vp_reset === e.rst) && (vp_halt === e.hlt);
          n_cmp++;
          if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual rdata=0x%0h err=%0b rst=0x%0h hlt=0x%0h expected rdata=0x%0h err=%0b rst=0x%0h hlt=0x%0h",
                     e.tag, rsp_rdata, rsp_err, vp_reset, vp_halt,
                     e.rdata, e.err, e.rst, e.hlt);
          end
        end
      end else if ((vp_reset | vp_halt) !== '0) begin
        check(1'b0, "R8 pulse outside command cycle",
              64'(vp_reset) | (64'(vp_halt) << 8), 64'd0);
      end
    end
  end

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin : main
    rst_n = 1'b0; req_valid = 1'b0; req_write = 1'b0; req_addr = '0; req_wdata = '0;
    repeat (3) @(negedge clk);
    check(rsp_valid === 1'b0, "R1 reset rsp_valid", 64'(rsp_valid), 64'd0);
    check(vp_reset === '0 && vp_halt === '0, "R1 reset pulses",
          64'(vp_reset) | (64'(vp_halt) << 8), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(vp_reset === NVP'(BOOT), "R1 boot reset pulse", 64'(vp_reset), BOOT);
    check(vp_halt === '0, "R1 boot no halt", 64'(vp_halt), 64'd0);
    model = BOOT;
    @(negedge clk);
    check(vp_reset === '0, "R8 boot pulse one cycle", 64'(vp_reset), 64'd0);
    mon_en = 1'b1;

    issue(1'b0, 12'h010, '0, "R1 R6 read after boot");
    issue(1'b1, 12'h000, 64'h0F, "R2 start new VPs");
    issue(1'b0, 12'h010, '0, "R6 read after start");
    issue(1'b1, 12'h100, 64'h03, "R2 R5 start running VPs via window B");
    issue(1'b1, 12'h108, 64'h11, "R3 R5 halt mixed via window B");
    issue(1'b0, 12'h110, '0, "R5 read via window B");
    issue(1'b1, 12'h000, 64'hFFFF_FFFF_FFFF_FFD0, "R4 start with high bits");
    issue(1'b1, 12'h008, 64'hFFFF_FFFF_FFFF_FFC0, "R4 halt only high bits");
    issue(1'b0, 12'h010, '0, "R4 read bitmap no high bits");
    issue(1'b0, 12'h008, '0, "R7 read halt register");
    issue(1'b0, 12'h200, '0, "R7 read outside windows");
    issue(1'b1, 12'h010, 64'h3F, "R7 write running register");
    issue(1'b1, 12'h018, 64'h3F, "R7 write bad offset");
    issue(1'b0, 12'h110, '0, "R7 bitmap unchanged");
    issue(1'b1, 12'h000, 64'h20, "R8 start then");
    issue(1'b1, 12'h108, 64'h20, "R8 halt back-to-back");
    issue(1'b0, 12'h010, '0, "R8 read after ordered pair");
    issue(1'b1, 12'h100, 64'h01, "R2 start one");
    issue(1'b0, 12'h010, '0, "R6 read right after start");
    issue(1'b1, 12'h008, 64'h3F, "R3 halt all");
    issue(1'b0, 12'h110, '0, "R3 read all halted");
    issue(1'b1, 12'h008, 64'h3F, "R3 halt already halted");
    issue(1'b1, 12'h000, 64'h3F, "R2 start all");
    issue(1'b0, 12'h010, '0, "R6 read all running");

    repeat (3) @(negedge clk);
    check(exp_q.size() == 0, "R6 all responses seen", 64'(exp_q.size()), 64'd0);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule